// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with Accumulator Pair

This block performs unsigned 16-bit multiplication and division, one result bit per clock. It suits a multi-cycle processor that has no room for a single-cycle array multiplier. A one-cycle start pulse launches an operation. The first operand always comes from a register. The second operand comes either from a register or from an instruction immediate, chosen by a select input. The unit raises busy while it works and pulses done when the result is ready.

The results never return directly to a general register. They are written into a dedicated pair of 16-bit accumulator registers, one high and one low. Those registers can be read at any time through two read ports, so separate move-from-high and move-from-low instructions can copy either half into the register file later. Multiplication uses a shift-add loop. Division uses a restoring loop. Both take one setup cycle followed by sixteen iterations.

Top module: `muldiv_accum`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy, done and div_err are 0 and both accumulator halves read 0.
- R2: A start that is sampled high at a clock edge while busy is low is accepted at that edge. From that edge on, busy reads 1 for exactly 17 cycles. At the 17th edge after the accepting edge, busy falls, done reads 1 for one cycle, and the accumulator is written.
- R3: With op_div = 0 the operation is a multiply. acc_hi receives bits 31..16 of the 32-bit unsigned product and acc_lo receives bits 15..0.
- R4: With op_div = 1 and a nonzero divisor the operation is a divide. acc_lo receives the unsigned quotient and acc_hi receives the remainder.
- R5: When use_imm = 1 at the accepting edge, imm is the second operand; when use_imm = 0, src_b is. src_a is always the first operand (the multiplicand or the dividend).
- R6: Dividing by zero produces acc_lo = 16'hFFFF, acc_hi = the dividend, and raises div_err at completion.
- R7: div_err stays at 1 through idle cycles. It is cleared at the edge that accepts the next start.
- R8: A start pulse that arrives while busy is 1 is ignored. The operands and operation select presented with it affect neither the result nor the completion time of the operation in flight.
- R9: The accumulator halves keep their previous values from one completion to the next, including the whole time busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches an operation when busy is low |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| use_imm | input | 1 | 1 takes imm as the second operand, 0 takes src_b |
| src_a | input | 16 | First operand (multiplicand or dividend) |
| src_b | input | 16 | Register second operand |
| imm | input | 16 | Immediate second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Sticky divide-by-zero flag |
| acc_hi | output | 16 | High accumulator read port |
| acc_lo | output | 16 | Low accumulator read port |

## Verification
Once a start is accepted, busy must appear one edge later. It must stay high for 17 sampled cycles, and done and the new accumulator contents must appear together exactly 17 edges after the accepting edge. The bench drives every input at the falling edge and samples at the falling edge after each rising edge. It walks that 17-cycle window one sample at a time, checking busy, the held accumulator values and the absence of done in each cycle. It then checks done, the results and div_err in the single sample where they are due. The error flag is checked both one sample after a later start is accepted, to confirm it has cleared, and across idle cycles before that, to confirm it persists.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int unsigned DW    = 16;
    localparam int unsigned ITERS = DW;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } md_state_e;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef struct packed {
        md_op_e          op;
        logic [DW-1:0]   a;
        logic [DW-1:0]   b;
    } md_req_t;

    // one shift-add multiply iteration on {hi, lo}
    function automatic logic [2*DW-1:0] mul_iter(
        input logic [DW-1:0] hi,
        input logic [DW-1:0] lo,
        input logic [DW-1:0] mcand
    );
        logic [DW:0] sum;
        sum = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);
        return {sum[DW:1], sum[0], lo[DW-1:1]};
    endfunction

    // one restoring divide iteration: hi = partial remainder, lo = quotient/dividend
    function automatic logic [2*DW-1:0] div_iter(
        input logic [DW-1:0] hi,
        input logic [DW-1:0] lo,
        input logic [DW-1:0] dvsr
    );
        logic [DW:0]   trial;
        logic          fits;
        logic [DW-1:0] rem_n;
        trial = {hi, lo[DW-1]};
        fits  = (trial >= {1'b0, dvsr});
        rem_n = fits ? (trial[DW-1:0] - dvsr) : trial[DW-1:0];
        return {rem_n, lo[DW-2:0], fits};
    endfunction

endpackage

// File: rtl/muldiv_opsel.sv
module muldiv_opsel
    import muldiv_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         use_imm,
    input  logic [W-1:0] reg_b,
    input  logic [W-1:0] imm_b,
    output logic [W-1:0] opnd_b
);
    always_comb begin
        opnd_b = use_imm ? imm_b : reg_b;
    end
endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine
    import muldiv_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  md_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W-1:0]   hi_q, lo_q, opnd_q;
    logic [2*W-1:0] iter;

    always_comb begin
        if (op == OP_DIV) iter = div_iter(hi_q, lo_q, opnd_q);
        else              iter = mul_iter(hi_q, lo_q, opnd_q);
        nxt_hi = iter[2*W-1:W];
        nxt_lo = iter[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            opnd_q <= '0;
        end else if (load) begin
            hi_q <= '0;
            if (op == OP_DIV) begin
                lo_q   <= a;   // dividend shifts out of lo
                opnd_q <= b;   // divisor
            end else begin
                lo_q   <= b;   // multiplier shifts out of lo
                opnd_q <= a;   // multiplicand
            end
        end else if (step) begin
            hi_q <= nxt_hi;
            lo_q <= nxt_lo;
        end
    end
endmodule

// File: rtl/muldiv_acc_regs.sv
module muldiv_acc_regs
    import muldiv_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_hi,
    input  logic [W-1:0] wr_lo,
    output logic [W-1:0] rd_hi,
    output logic [W-1:0] rd_lo
);
    logic [W-1:0] acc_q [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q[0] <= '0;
            acc_q[1] <= '0;
        end else if (wr_en) begin
            acc_q[0] <= wr_lo;
            acc_q[1] <= wr_hi;
        end
    end

    assign rd_lo = acc_q[0];
    assign rd_hi = acc_q[1];
endmodule

// File: rtl/muldiv_accum.sv
module muldiv_accum
    import muldiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_div,
    input  logic          use_imm,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] imm,
    output logic          busy,
    output logic          done,
    output logic          div_err,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo
);
    localparam int unsigned CW = $clog2(ITERS);
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    md_state_e     state_q;
    md_req_t       req_q;
    logic [CW-1:0] cnt_q;
    logic          done_q, err_q;
    logic          accept, finish;
    logic [DW-1:0] opnd_b, nxt_hi, nxt_lo;

    assign accept = start && (state_q == ST_IDLE);
    assign finish = (state_q == ST_RUN) && (cnt_q == LAST);

    muldiv_opsel #(.W(DW)) u_opsel (
        .use_imm (use_imm),
        .reg_b   (src_b),
        .imm_b   (imm),
        .opnd_b  (opnd_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_q.op <= op_div ? OP_DIV : OP_MUL;
                        req_q.a  <= src_a;
                        req_q.b  <= opnd_b;
                        err_q    <= 1'b0;
                        state_q  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt_q   <= '0;
                    state_q <= ST_RUN;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (finish) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= (req_q.op == OP_DIV) && (req_q.b == '0);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    muldiv_engine #(.W(DW)) u_engine (
        .clk    (clk),
        .rst    (rst),
        .load   (state_q == ST_SETUP),
        .step   (state_q == ST_RUN),
        .op     (req_q.op),
        .a      (req_q.a),
        .b      (req_q.b),
        .nxt_hi (nxt_hi),
        .nxt_lo (nxt_lo)
    );

    muldiv_acc_regs #(.W(DW)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .wr_en (finish),
        .wr_hi (nxt_hi),
        .wr_lo (nxt_lo),
        .rd_hi (acc_hi),
        .rd_lo (acc_lo)
    );

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign div_err = err_q;
endmodule

// File: rtl/muldiv_accum_chk.sv
module muldiv_accum_chk
    import muldiv_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          op_div,
    input logic          use_imm,
    input logic [DW-1:0] src_a,
    input logic [DW-1:0] src_b,
    input logic [DW-1:0] imm,
    input logic          busy,
    input logic          done,
    input logic          div_err,
    input logic [DW-1:0] acc_hi,
    input logic [DW-1:0] acc_lo
);
    localparam int unsigned DUE = ITERS + 1;
    localparam int unsigned KW  = $clog2(DUE + 1);

    logic [KW-1:0]   since_q;
    logic            exp_div;
    logic [DW-1:0]   exp_a, exp_b;
    logic [2*DW-1:0] exp_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            exp_div <= 1'b0;
            exp_a   <= '0;
            exp_b   <= '0;
        end else if (start && !busy) begin
            since_q <= '0;
            exp_div <= op_div;
            exp_a   <= src_a;
            exp_b   <= use_imm ? imm : src_b;
        end else if (busy) begin
            since_q <= since_q + 1'b1;
        end
    end

    assign exp_prod = {{DW{1'b0}}, exp_a} * {{DW{1'b0}}, exp_b};

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!busy && !done && !div_err && acc_hi == '0 && acc_lo == '0));

    a_r2_busy_rises: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r2_done_due: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && since_q == KW'(DUE)));

    a_r3_mul_result: assert property (@(posedge clk) disable iff (rst)
        (done && !exp_div) |-> ({acc_hi, acc_lo} == exp_prod));

    a_r4_div_result: assert property (@(posedge clk) disable iff (rst)
        (done && exp_div && exp_b != '0) |->
            (acc_lo == exp_a / exp_b && acc_hi == exp_a % exp_b && !div_err));

    a_r6_div_zero: assert property (@(posedge clk) disable iff (rst)
        (done && exp_div && exp_b == '0) |->
            (acc_lo == '1 && acc_hi == exp_a && div_err));

    a_r7_err_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !div_err);

    a_r9_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (!$stable(acc_hi) || !$stable(acc_lo)) |-> done);
endmodule

bind muldiv_accum muldiv_accum_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_div  (op_div),
    .use_imm (use_imm),
    .src_a   (src_a),
    .src_b   (src_b),
    .imm     (imm),
    .busy    (busy),
    .done    (done),
    .div_err (div_err),
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo)
);

// File: tb/muldiv_accum_bench.sv
module muldiv_accum_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  BUSY_CYC   = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, op_div = 1'b0, use_imm = 1'b0;
    logic [15:0] src_a = '0, src_b = '0, imm = '0;
    logic        busy, done, div_err;
    logic [15:0] acc_hi, acc_lo;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    muldiv_accum u_muldiv_accum (
        .clk (clk), .rst (rst), .start (start), .op_div (op_div),
        .use_imm (use_imm), .src_a (src_a), .src_b (src_b), .imm (imm),
        .busy (busy), .done (done), .div_err (div_err),
        .acc_hi (acc_hi), .acc_lo (acc_lo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // launch one operation and follow it to completion;
    // poke = 1 throws a second start with junk operands mid-run (R8)
    task automatic run_op(input string tag, input logic div, input logic ui,
                          input logic [15:0] a, input logic [15:0] b, input logic [15:0] im,
                          input logic poke);
        logic [15:0] bo;
        logic [31:0] exp_acc;
        logic        exp_err;
        logic [15:0] old_hi, old_lo;
        bo = ui ? im : b;
        if (!div) begin
            exp_acc = {16'h0, a} * {16'h0, bo};
            exp_err = 1'b0;
        end else if (bo == 16'h0) begin
            exp_acc = {a, 16'hFFFF};
            exp_err = 1'b1;
        end else begin
            exp_acc = {a % bo, a / bo};
            exp_err = 1'b0;
        end
        @(negedge clk);
        old_hi = acc_hi; old_lo = acc_lo;
        start = 1'b1; op_div = div; use_imm = ui; src_a = a; src_b = b; imm = im;
        @(negedge clk);
        start = 1'b0; src_a = ~a; src_b = ~b; imm = ~im; op_div = ~div;
        chk({tag, " R7 err cleared by accepted start"}, {31'h0, div_err}, 32'h0);
        for (int i = 0; i < BUSY_CYC; i++) begin
            if (i != 0) @(negedge clk);
            chk({tag, " R2 busy during run"}, {31'h0, busy}, 32'h1);
            chk({tag, " R2 no early done"}, {31'h0, done}, 32'h0);
            chk({tag, " R9 acc held while busy"}, {acc_hi, acc_lo}, {old_hi, old_lo});
            if (poke && i == 5) begin
                start = 1'b1; op_div = 1'b1; use_imm = 1'b0;
                src_a = 16'h0001; src_b = 16'h0000;
            end else begin
                start = 1'b0;
            end
        end
        @(negedge clk);
        chk({tag, " R2 busy falls at due cycle"}, {31'h0, busy}, 32'h0);
        chk({tag, " R2 done at due cycle"}, {31'h0, done}, 32'h1);
        chk({tag, div ? " R4/R6 divide result" : " R3 multiply result"},
            {acc_hi, acc_lo}, exp_acc);
        chk({tag, " R6 error flag"}, {31'h0, div_err}, {31'h0, exp_err});
        @(negedge clk);
        chk({tag, " R2 done lasts one cycle"}, {31'h0, done}, 32'h0);
        chk({tag, " R9 acc held after done"}, {acc_hi, acc_lo}, exp_acc);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'h0, busy}, 32'h0);
        chk("R1 acc in reset", {acc_hi, acc_lo}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", {31'h0, done}, 32'h0);
        chk("R1 err after reset", {31'h0, div_err}, 32'h0);
        chk("R1 acc after reset", {acc_hi, acc_lo}, 32'h0);
    endtask

    task automatic t_multiply();
        run_op("R3 max*max", 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0);
        run_op("R3 R5 imm", 1'b0, 1'b1, 16'd1234, 16'hAAAA, 16'd6, 1'b0);
        run_op("R3 by zero", 1'b0, 1'b0, 16'h8001, 16'h0000, 16'h1111, 1'b0);
    endtask

    task automatic t_divide();
        run_op("R4 reg", 1'b1, 1'b0, 16'd1000, 16'd7, 16'h0000, 1'b0);
        run_op("R4 R5 imm", 1'b1, 1'b1, 16'hFFFF, 16'h0000, 16'd4, 1'b0);
        run_op("R4 small/large", 1'b1, 1'b0, 16'd5, 16'd9, 16'h0000, 1'b0);
    endtask

    task automatic t_div_zero_sticky();
        run_op("R6 zero", 1'b1, 1'b0, 16'hBEEF, 16'h0000, 16'h0003, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7 err sticky while idle", {31'h0, div_err}, 32'h1);
        chk("R9 acc held while idle", {acc_hi, acc_lo}, 32'hBEEF_FFFF);
    endtask

    task automatic t_start_ignored();
        // also clears the error left by t_div_zero_sticky (R7)
        run_op("R8 poke", 1'b0, 1'b0, 16'd300, 16'd211, 16'h0000, 1'b1);
    endtask

    initial begin
        t_reset();
        t_multiply();
        t_divide();
        t_div_zero_sticky();
        t_start_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule